// File: doc/BRIEF.md
# ADC Register and Conversion Sequencer Front End

This block is the bus-facing side of a 10-bit analog-to-digital converter that is attached to an 8-bit CPU bus. It holds one 8-bit control/status register and four 16-bit result registers. It issues conversion requests to an external analog core, one channel at a time, and files each returned code into the result register that belongs to that channel. The analog core itself is outside the block. The block sends it a one-cycle start pulse with a 3-bit channel number and gets back a done strobe carrying the code.

Software can ask for two kinds of run. In single mode the block converts one channel once. In scan mode it walks a range of channels inside one group of four and repeats the walk until software stops it. A result is kept left-justified, so an 8-bit read of the high byte gives the top eight bits of the code. A 16-bit value is read as two byte accesses. Reading the high byte freezes the matching low byte in a temporary latch, so the two halves always come from the same conversion. A done flag raises an interrupt when the enable bit is set. Software can clear this flag only by first reading it as 1 and then writing 0 to it.

Top module: `adc_bus_front`

## Requirements
- R1: A code `c[9:0]` is stored as `{c, 6'b0}`. The high byte (address 2k) reads `c[9:2]`. The low byte reads `{c[1:0], 6'b0}` once it has passed through the latch.
- R2: Channel n writes result register n mod 4, at byte addresses 2·(n mod 4) for the high byte and 2·(n mod 4)+1 for the low byte.
- R3: A high-byte read (even address 0..6) copies that register's low byte into a temporary latch at the same clock edge. A low-byte read (odd address 1..7) of any register returns the latch, not the register.
- R4: After reset, and in the cycle after `lowPower` is high, the control register (address 8), all result registers, the latch and `irq` are 0.
- R5: Control register layout: bit 7 done flag, bit 6 interrupt enable, bit 5 start, bit 4 scan, bit 3 clock select, bits 2:0 channel. Writing 1 to bit 7 has no effect. Writing 0 clears the flag only if the most recent control access was a read that returned bit 7 as 1.
- R6: In single mode, setting start produces one conversion of channel bits 2:0. Its completion sets the flag and clears start.
- R7: In scan mode with channel s, the block converts channels {s[2],00} through s in ascending order and repeats. It sets the flag after channel s, and issues no new request once start is 0. A request that is already outstanding still completes.
- R8: `irq` is 1 exactly while the done flag and the interrupt enable are both 1.
- R9: `convStart` is never high for two cycles in a row. A `convDone` with no outstanding request changes no register.
- R10: Control bits 6:0 read back as written, and `clkSel` follows bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowPower | input | 1 | Synchronous clear of all registers (standby / module stop) |
| busAddr | input | 4 | Byte address: 0..7 result bytes, 8 control |
| busRdEn | input | 1 | Read strobe, one access per cycle |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid in the cycle of the read, 0 otherwise |
| convStart | output | 1 | One-cycle request to the analog core |
| convChan | output | 3 | Channel of the current request |
| convDone | input | 1 | Completion strobe from the analog core |
| convCode | input | 10 | Converted code, valid with convDone |
| irq | output | 1 | Conversion-complete interrupt |
| clkSel | output | 1 | Conversion clock select to the analog core |

## Verification
The hardest case to reach is a scan stopped while a conversion is in flight. The stimulus waits for the request of a middle channel and clears start before the done strobe arrives. It then checks that the late result is still filed, that the flag stays clear because the pass did not finish, and that no further request follows. A second hard case is latch coherency. A high byte is read, the same register is then overwritten by a new conversion, and the following low-byte read must still return the old half.

// File: rtl/adc_front_pkg.sv
package adc_front_pkg;
  localparam int CTRL_W   = 8;
  localparam int CHAN_W   = 3;
  localparam int NUM_REGS = 2 ** (CHAN_W - 1);
  localparam int IDX_W    = CHAN_W - 1;

  localparam int BIT_FLAG  = 7;
  localparam int BIT_IE    = 6;
  localparam int BIT_START = 5;
  localparam int BIT_SCAN  = 4;
  localparam int BIT_CKS   = 3;

  typedef struct packed {
    logic             wrResult;
    logic [IDX_W-1:0] resIdx;
    logic             setFlag;
    logic             clrStart;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_front_dp.sv
module adc_front_dp
  import adc_front_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lowPower,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRdEn,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  ctlStrobe_t            strobe,
  input  logic [RES_W-1:0]      convCode,
  output logic [CTRL_W-1:0]     ctrlQ
);
  localparam int WORD_W    = 2 * DATA_W;
  localparam int PAD_W     = WORD_W - RES_W;
  localparam int CTRL_ADDR = 2 * NUM_REGS;

  logic [NUM_REGS-1:0][WORD_W-1:0] dataQ;
  logic [DATA_W-1:0] tempQ;
  logic              armQ;
  logic [CTRL_W-1:0] ctrlNext;

  logic             isData, lowSel, rdHigh, rdCtrl, wrCtrl;
  logic [IDX_W-1:0] regSel;

  assign isData = busAddr < ADDR_W'(CTRL_ADDR);
  assign lowSel = busAddr[0];
  assign regSel = busAddr[IDX_W:1];
  assign rdHigh = busRdEn && isData && !lowSel;
  assign rdCtrl = busRdEn && (busAddr == ADDR_W'(CTRL_ADDR));
  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    busRdData = '0;
    if (rdCtrl)
      busRdData = DATA_W'(ctrlQ);
    else if (busRdEn && isData)
      busRdData = lowSel ? tempQ : dataQ[regSel][WORD_W-1:DATA_W];
  end

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrCtrl) begin
      ctrlNext[BIT_IE:0] = busWrData[BIT_IE:0];
      if (!busWrData[BIT_FLAG] && armQ) ctrlNext[BIT_FLAG] = 1'b0;
    end
    if (strobe.clrStart) ctrlNext[BIT_START] = 1'b0;
    if (strobe.setFlag)  ctrlNext[BIT_FLAG]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      armQ  <= 1'b0;
      tempQ <= '0;
      dataQ <= '0;
    end else if (lowPower) begin
      ctrlQ <= '0;
      armQ  <= 1'b0;
      tempQ <= '0;
      dataQ <= '0;
    end else begin
      ctrlQ <= ctrlNext;
      if (rdCtrl)      armQ <= ctrlQ[BIT_FLAG];
      else if (wrCtrl) armQ <= 1'b0;
      if (rdHigh) tempQ <= dataQ[regSel][DATA_W-1:0];
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobe.wrResult && (strobe.resIdx == IDX_W'(i)))
          dataQ[i] <= {convCode, {PAD_W{1'b0}}};
      end
    end
  end

  // R6: a completion that sets the flag is visible in the next cycle
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setFlag && !lowPower |=> ctrlQ[BIT_FLAG]);

  // R6: hardware clearing of start takes effect
  p_clear_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrStart && !lowPower |=> !ctrlQ[BIT_START]);

  // R5: the flag survives any cycle without an armed zero-write or low power
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[BIT_FLAG] && !lowPower && !(wrCtrl && armQ && !busWrData[BIT_FLAG])
    |=> ctrlQ[BIT_FLAG]);

  // R3: a high-byte read captures the low half of the same register
  p_temp_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdHigh && !lowPower |=> tempQ == $past(dataQ[regSel][DATA_W-1:0]));
endmodule

// File: rtl/adc_front_ctl.sv
module adc_front_ctl
  import adc_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPower,
  input  logic [CTRL_W-1:0] ctrlQ,
  input  logic              convDone,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output ctlStrobe_t        strobe
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;

  state_t            stateQ;
  logic [CHAN_W-1:0] chanQ, nextChanQ;
  logic              midScanQ, startQ;

  logic              startBit, scanBit, accept, lastInPass;
  logic [CHAN_W-1:0] selCh, groupFirst, firstChan;

  assign startBit   = ctrlQ[BIT_START];
  assign scanBit    = ctrlQ[BIT_SCAN];
  assign selCh      = ctrlQ[CHAN_W-1:0];
  assign groupFirst = {selCh[CHAN_W-1], {(CHAN_W-1){1'b0}}};
  assign firstChan  = !scanBit ? selCh : (midScanQ ? nextChanQ : groupFirst);
  assign accept     = (stateQ == ST_WAIT) && convDone;
  assign lastInPass = chanQ[IDX_W-1:0] >= selCh[IDX_W-1:0];

  always_comb begin
    strobe          = '0;
    strobe.wrResult = accept;
    strobe.resIdx   = chanQ[IDX_W-1:0];
    strobe.setFlag  = accept && (!scanBit || lastInPass);
    strobe.clrStart = accept && !scanBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      chanQ     <= '0;
      nextChanQ <= '0;
      midScanQ  <= 1'b0;
      startQ    <= 1'b0;
    end else if (lowPower) begin
      stateQ    <= ST_IDLE;
      midScanQ  <= 1'b0;
      startQ    <= 1'b0;
    end else begin
      startQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (startBit) begin
            chanQ  <= firstChan;
            startQ <= 1'b1;
            stateQ <= ST_WAIT;
          end else begin
            midScanQ <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (convDone) begin
            stateQ    <= ST_IDLE;
            midScanQ  <= scanBit && !lastInPass;
            nextChanQ <= chanQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign convStart = startQ;
  assign convChan  = chanQ;

  // R9: the request is a single-cycle pulse
  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R9: a request is only raised while a conversion is outstanding
  p_start_waiting_r9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> stateQ == ST_WAIT);
endmodule

// File: rtl/adc_bus_front.sv
module adc_bus_front
  import adc_front_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPower,
  input  logic [3:0]        busAddr,
  input  logic              busRdEn,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convCode,
  output logic              irq,
  output logic              clkSel
);
  ctlStrobe_t        strobe;
  logic [CTRL_W-1:0] ctrlQ;

  adc_front_dp #(.DATA_W(DATA_W), .RES_W(RES_W), .ADDR_W(4)) u_dp (
    .clk(clk), .rstN(rstN), .lowPower(lowPower),
    .busAddr(busAddr), .busRdEn(busRdEn), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .strobe(strobe), .convCode(convCode), .ctrlQ(ctrlQ)
  );

  adc_front_ctl u_ctl (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .ctrlQ(ctrlQ),
    .convDone(convDone), .convStart(convStart), .convChan(convChan),
    .strobe(strobe)
  );

  assign irq    = ctrlQ[BIT_FLAG] && ctrlQ[BIT_IE];
  assign clkSel = ctrlQ[BIT_CKS];
endmodule

// File: tb/adc_bus_front_bench.sv
`timescale 1ns/1ps
module adc_bus_front_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lowPower = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busRdEn = 1'b0, busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       convStart;
  logic [2:0] convChan;
  logic       convDone = 1'b0;
  logic [9:0] convCode = '0;
  logic       irq, clkSel;

  int checks = 0, failures = 0;
  int startSeen = 0, startsTaken = 0, pulseErr = 0;
  logic [2:0] lastChan = '0;
  logic prevStart = 1'b0;

  always #2.5 clk = ~clk;

  adc_bus_front u_adc_bus_front (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .busAddr(busAddr),
    .busRdEn(busRdEn), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .convStart(convStart), .convChan(convChan),
    .convDone(convDone), .convCode(convCode), .irq(irq), .clkSel(clkSel)
  );

  always @(negedge clk) begin
    if (convStart) begin
      startSeen <= startSeen + 1;
      lastChan  <= convChan;
      if (prevStart) pulseErr <= pulseErr + 1;
    end
    prevStart <= convStart;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 v = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitStart(input string req, input logic [2:0] expChan);
    int n = 0;
    while (startSeen <= startsTaken && n < 50) begin
      @(negedge clk);
      n++;
    end
    #1;
    chk({req, " request issued"}, 16'(startSeen > startsTaken), 16'd1);
    startsTaken++;
    chk({req, " channel"}, 16'(lastChan), 16'(expChan));
  endtask

  task automatic finishConv(input logic [9:0] code);
    @(negedge clk);
    @(negedge clk);
    convDone = 1'b1; convCode = code;
    @(negedge clk);
    convDone = 1'b0; convCode = '0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    busRead(4'd8, v); chk("R4 ctrl after reset", 16'(v), 16'h00);
    for (int k = 0; k < 4; k++) begin
      busRead(4'(2 * k), v); chk("R4 data after reset", 16'(v), 16'h00);
    end
    chk("R4 irq after reset", 16'(irq), 16'd0);
    busWrite(4'd8, 8'h0B);
    busRead(4'd8, v); chk("R10 ctrl readback", 16'(v), 16'h0B);
    chk("R10 clkSel follows bit 3", 16'(clkSel), 16'd1);
    repeat (4) @(negedge clk);
    chk("R6 no request without start", 16'(startSeen), 16'd0);
  endtask

  task automatic testSingle();
    logic [7:0] v;
    busWrite(4'd8, 8'h25);
    waitStart("R6 single", 3'd5);
    finishConv(10'h2D7);
    busRead(4'd8, v); chk("R6 flag set, start cleared", 16'(v), 16'h85);
    busRead(4'd2, v); chk("R1 R2 ch5 high byte in reg B", 16'(v), 16'hB5);
    busRead(4'd3, v); chk("R1 low byte via latch", 16'(v), 16'hC0);
    busRead(4'd0, v); chk("R2 reg A untouched", 16'(v), 16'h00);
    repeat (4) @(negedge clk);
    chk("R6 only one conversion", 16'(startSeen), 16'(startsTaken));
  endtask

  task automatic testFlagIrq();
    logic [7:0] v;
    busRead(4'd8, v);
    busWrite(4'd8, 8'h85);
    busRead(4'd8, v); chk("R5 writing 1 leaves flag", 16'(v), 16'h85);
    busWrite(4'd8, 8'hC5);
    #1 chk("R8 irq with flag and enable", 16'(irq), 16'd1);
    busWrite(4'd8, 8'h45);
    #1 chk("R5 unarmed zero-write keeps flag", 16'(irq), 16'd1);
    busRead(4'd8, v); chk("R5 flag still set", 16'(v), 16'hC5);
    busWrite(4'd8, 8'h45);
    #1 chk("R8 irq drops with flag", 16'(irq), 16'd0);
    busRead(4'd8, v); chk("R5 armed zero-write clears", 16'(v), 16'h45);
  endtask

  task automatic testLatch();
    logic [7:0] v;
    busWrite(4'd8, 8'h21);
    waitStart("R2 ch1", 3'd1);
    finishConv(10'h155);
    busRead(4'd2, v); chk("R1 ch1 high", 16'(v), 16'h55);
    busWrite(4'd8, 8'h21);
    waitStart("R6 ch1 again", 3'd1);
    finishConv(10'h3FF);
    busRead(4'd3, v); chk("R3 low keeps old half", 16'(v), 16'h40);
    busRead(4'd2, v); chk("R3 new high", 16'(v), 16'hFF);
    busRead(4'd1, v); chk("R3 any low address returns latch", 16'(v), 16'hC0);
    @(negedge clk);
    convDone = 1'b1; convCode = 10'h000;
    @(negedge clk);
    convDone = 1'b0;
    busRead(4'd2, v); chk("R9 stray done ignored", 16'(v), 16'hFF);
  endtask

  task automatic testScan();
    logic [7:0] v;
    busRead(4'd8, v);
    busWrite(4'd8, 8'h36);
    waitStart("R7 scan first", 3'd4); finishConv(10'h001);
    waitStart("R7 scan second", 3'd5); finishConv(10'h200);
    busRead(4'd8, v); chk("R7 no flag mid pass", 16'(v), 16'h36);
    waitStart("R7 scan third", 3'd6); finishConv(10'h0F0);
    busRead(4'd8, v); chk("R7 flag after pass", 16'(v), 16'hB6);
    waitStart("R7 scan wraps", 3'd4); finishConv(10'h3C3);
    waitStart("R7 scan continues", 3'd5);
    busWrite(4'd8, 8'h16);
    finishConv(10'h004);
    busRead(4'd8, v); chk("R7 stop mid pass, no flag", 16'(v), 16'h16);
    repeat (10) @(negedge clk);
    chk("R7 no request after stop", 16'(startSeen), 16'(startsTaken));
    busRead(4'd4, v); chk("R2 ch6 to reg C", 16'(v), 16'h3C);
    busRead(4'd0, v); chk("R7 second pass result in A", 16'(v), 16'hF0);
    busRead(4'd2, v); chk("R7 in-flight result filed", 16'(v), 16'h01);
    chk("R9 single-cycle request", 16'(pulseErr), 16'd0);
  endtask

  task automatic testLowPower();
    logic [7:0] v;
    busWrite(4'd8, 8'h48);
    @(negedge clk); lowPower = 1'b1;
    @(negedge clk); lowPower = 1'b0;
    busRead(4'd8, v); chk("R4 ctrl cleared", 16'(v), 16'h00);
    chk("R4 clkSel cleared", 16'(clkSel), 16'd0);
    for (int k = 0; k < 4; k++) begin
      busRead(4'(2 * k), v); chk("R4 data cleared", 16'(v), 16'h00);
    end
    busRead(4'd7, v); chk("R4 latch cleared", 16'(v), 16'h00);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testFlagIrq();
    testLatch();
    testScan();
    testLowPower();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule